// File: doc/BRIEF.md
# Message Playback Sequencer

This block sequences playback in a speech and sound engine. A host selects a message by placing an 8-bit code on `msg_code` and pulsing the active-low start strobe `st_n` while chip select `cs_n` is low. The code is captured on the rising edge of the strobe and presented on `msg_sel`. A single-cycle `play_go` pulse then tells the downstream decoder to begin. While a message is being prepared or played, the active-low `busy_n` output is driven low and further start strobes have no effect.

The analog stage is driven through a 9-bit unsigned code on `dac_code`. 000h is zero output, 100h is midscale and 1FFh is full scale. Silence during playback is midscale. After a message ends, the block waits for a programmable number of clocks. It then ramps the code down to zero one step at a time and enters a low-power standby state. In standby the converter enable and the busy output enable are released. A start strobe in standby ramps the code back up to midscale before playback begins, so neither transition produces a click. A reset request must be held low for a minimum number of clocks to take effect.

Top module: `msg_playback_ctl`

## Requirements
- R1: Holding `rst_n` low for at least RST_MIN consecutive clock edges returns the block to standby and clears `msg_sel` to 0. A low pulse shorter than RST_MIN edges has no effect on any output.
- R2: A start is taken when `st_n` is sampled high one edge after being sampled low while `cs_n` is sampled low. The code on `msg_code` in that cycle appears on `msg_sel`. The same strobe with `cs_n` high does nothing.
- R3: `busy_n` is low from the edge that takes a start until the message ends. Strobes arriving while `busy_n` is low leave `msg_sel` and all other outputs unchanged.
- R4: A start taken in standby raises `dac_en` and steps `dac_code` up by one every RAMP_DIV clocks, from 000h to 100h. On the edge where it reaches 100h, `play_go` pulses high for one cycle.
- R5: During playback `dac_code` follows `dec_sample` in the same cycle. A high `dec_done` at an edge returns `dac_code` to 100h and raises `busy_n` after that edge.
- R6: A start taken while idle at midscale pulses `play_go` for one cycle on the next edge, with no ramp.
- R7: After IDLE_CYC clocks idle at midscale without a start, `dac_code` steps down by one every RAMP_DIV clocks to 000h. The block then enters standby.
- R8: A start taken during the ramp down reverses the ramp from the current code, climbs to 100h and then pulses `play_go`.
- R9: In standby `busy_oe` and `dac_en` are low, `busy_n` is high and `dac_code` is 000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset request, active low, qualified by minimum width |
| cs_n | input | 1 | Chip select, active low, qualifies the start strobe |
| st_n | input | 1 | Start strobe, active low, acts on its rising edge |
| msg_code | input | CODE_W | Message selection code |
| dec_done | input | 1 | Decoder reports end of message |
| dec_sample | input | DAC_W | Decoder output sample |
| busy_n | output | 1 | Busy flag, active low |
| busy_oe | output | 1 | Output enable for the busy pin, low in standby |
| msg_sel | output | CODE_W | Captured message code |
| play_go | output | 1 | One-cycle pulse to start the decoder |
| dac_code | output | DAC_W | Converter code |
| dac_en | output | 1 | Converter enable |

## Verification
Two functions can meet on one edge: a start being taken and a ramp step of the ramp down. When a strobe completes on an edge where the divider would also have stepped the code, the start must win. In that case the code is held, the divider restarts and the ramp climbs from the held value. The bench repeats the ramp-down interruption at two strobe offsets one clock apart, so that both phases of the divider are hit. Its behavioural model compares every output on every clock to show that the step is dropped rather than applied.

// File: rtl/msgctl_pkg.sv
package msgctl_pkg;

   typedef enum logic [2:0] {
      PH_STBY  = 3'd0,
      PH_WAKE  = 3'd1,
      PH_PLAY  = 3'd2,
      PH_IDLE  = 3'd3,
      PH_SLEEP = 3'd4
   } phase_t;

   function automatic logic phase_busy(phase_t p);
      return (p == PH_WAKE) || (p == PH_PLAY);
   endfunction

   function automatic logic phase_ramp(phase_t p);
      return (p == PH_WAKE) || (p == PH_SLEEP);
   endfunction

endpackage

// File: rtl/msgctl_rst_gate.sv
module msgctl_rst_gate #(
   parameter int HOLD = 12
) (
   input  logic clk,
   input  logic rst_n,
   output logic rst_hold
);
   localparam int CW = $clog2(HOLD + 1);
   localparam logic [CW-1:0] LIM = CW'(HOLD);

   logic [CW-1:0] low_cnt = '0;

   always_ff @(posedge clk) begin
      if (rst_n)
         low_cnt <= '0;
      else if (low_cnt != LIM)
         low_cnt <= low_cnt + 1'b1;
   end

   assign rst_hold = (low_cnt == LIM);
endmodule

// File: rtl/msgctl_strobe.sv
module msgctl_strobe (
   input  logic clk,
   input  logic rst_hold,
   input  logic st_n,
   input  logic cs_n,
   output logic rise_sel
);
   logic st_q;

   always_ff @(posedge clk) begin
      if (rst_hold)
         st_q <= 1'b1;
      else
         st_q <= st_n;
   end

   assign rise_sel = st_n & ~st_q & ~cs_n;
endmodule

// File: rtl/msgctl_ramp_tick.sv
module msgctl_ramp_tick #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic clr,
   input  logic run,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] div_cnt;

   always_ff @(posedge clk) begin
      if (clr || !run)
         div_cnt <= '0;
      else if (div_cnt == LAST)
         div_cnt <= '0;
      else
         div_cnt <= div_cnt + 1'b1;
   end

   assign tick = run && !clr && (div_cnt == LAST);
endmodule

// File: rtl/msg_playback_ctl.sv
module msg_playback_ctl
   import msgctl_pkg::*;
#(
   parameter int CODE_W   = 8,
   parameter int DAC_W    = 9,
   parameter int RST_MIN  = 12,
   parameter int RAMP_DIV = 4,
   parameter int IDLE_CYC = 1920000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              st_n,
   input  logic [CODE_W-1:0] msg_code,
   input  logic              dec_done,
   input  logic [DAC_W-1:0]  dec_sample,
   output logic              busy_n,
   output logic              busy_oe,
   output logic [CODE_W-1:0] msg_sel,
   output logic              play_go,
   output logic [DAC_W-1:0]  dac_code,
   output logic              dac_en
);
   localparam logic [DAC_W-1:0] MID  = {1'b1, {(DAC_W-1){1'b0}}};
   localparam logic [DAC_W-1:0] ZERO = '0;
   localparam int IW = $clog2(IDLE_CYC + 1);
   localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_CYC - 1);

   initial begin : param_guard
      assert (CODE_W >= 1)   else $error("CODE_W must be at least 1");
      assert (DAC_W >= 2)    else $error("DAC_W must be at least 2");
      assert (RST_MIN >= 1)  else $error("RST_MIN must be at least 1");
      assert (RAMP_DIV >= 1) else $error("RAMP_DIV must be at least 1");
      assert (IDLE_CYC >= 1) else $error("IDLE_CYC must be at least 1");
   end

   logic             rst_hold;
   logic             rise_sel;
   logic             take;
   logic             ramp_run;
   logic             ramp_tick;
   phase_t           phase;
   logic [DAC_W-1:0] dac_reg;
   logic [IW-1:0]    idle_cnt;
   logic [CODE_W-1:0] code_q;
   logic             go_q;
   logic [DAC_W-1:0] dac_up;
   logic [DAC_W-1:0] dac_dn;

   msgctl_rst_gate #(.HOLD(RST_MIN)) u_rst (
      .clk      (clk),
      .rst_n    (rst_n),
      .rst_hold (rst_hold)
   );

   msgctl_strobe u_stb (
      .clk      (clk),
      .rst_hold (rst_hold),
      .st_n     (st_n),
      .cs_n     (cs_n),
      .rise_sel (rise_sel)
   );

   assign take     = rise_sel && !phase_busy(phase);
   assign ramp_run = phase_ramp(phase);

   msgctl_ramp_tick #(.DIV(RAMP_DIV)) u_tick (
      .clk  (clk),
      .clr  (rst_hold | take),
      .run  (ramp_run),
      .tick (ramp_tick)
   );

   assign dac_up = dac_reg + 1'b1;
   assign dac_dn = dac_reg - 1'b1;

   always_ff @(posedge clk) begin
      if (rst_hold) begin
         phase    <= PH_STBY;
         dac_reg  <= ZERO;
         idle_cnt <= '0;
         code_q   <= '0;
         go_q     <= 1'b0;
      end else begin
         go_q <= 1'b0;
         if (phase == PH_IDLE && !take)
            idle_cnt <= idle_cnt + 1'b1;
         else
            idle_cnt <= '0;
         if (take)
            code_q <= msg_code;
         unique case (phase)
            PH_STBY: begin
               if (take)
                  phase <= PH_WAKE;
            end
            PH_WAKE: begin
               if (ramp_tick) begin
                  dac_reg <= dac_up;
                  if (dac_up == MID) begin
                     phase <= PH_PLAY;
                     go_q  <= 1'b1;
                  end
               end
            end
            PH_PLAY: begin
               if (dec_done)
                  phase <= PH_IDLE;
            end
            PH_IDLE: begin
               if (take) begin
                  phase <= PH_PLAY;
                  go_q  <= 1'b1;
               end else if (idle_cnt == IDLE_LAST) begin
                  phase <= PH_SLEEP;
               end
            end
            PH_SLEEP: begin
               if (take) begin
                  if (dac_reg == MID) begin
                     phase <= PH_PLAY;
                     go_q  <= 1'b1;
                  end else begin
                     phase <= PH_WAKE;
                  end
               end else if (ramp_tick) begin
                  dac_reg <= dac_dn;
                  if (dac_dn == ZERO)
                     phase <= PH_STBY;
               end
            end
            default: phase <= PH_STBY;
         endcase
      end
   end

   assign busy_n   = !phase_busy(phase);
   assign busy_oe  = (phase != PH_STBY);
   assign dac_en   = (phase != PH_STBY);
   assign msg_sel  = code_q;
   assign play_go  = go_q;
   assign dac_code = (phase == PH_PLAY) ? dec_sample : dac_reg;
endmodule

// File: rtl/msgctl_chk.sv
module msgctl_chk
   import msgctl_pkg::*;
#(
   parameter int CODE_W = 8,
   parameter int DAC_W  = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rst_hold,
   input phase_t            phase,
   input logic [DAC_W-1:0]  dac_reg,
   input logic              busy_n,
   input logic              busy_oe,
   input logic              dac_en,
   input logic [DAC_W-1:0]  dac_code,
   input logic              play_go,
   input logic              dec_done,
   input logic [CODE_W-1:0] msg_sel
);
   localparam logic [DAC_W-1:0] MID = {1'b1, {(DAC_W-1){1'b0}}};

   // R9
   standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || rst_hold)
      !busy_oe |-> (dac_code == '0 && !dac_en && busy_n));

   // R3
   code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || rst_hold)
      !busy_n |=> $stable(msg_sel));

   // R4
   wake_step_chk: assert property (@(posedge clk) disable iff (!rst_n || rst_hold)
      (phase == PH_WAKE) |=> (dac_reg == $past(dac_reg) || dac_reg == $past(dac_reg) + 1'b1));

   // R7
   sleep_step_chk: assert property (@(posedge clk) disable iff (!rst_n || rst_hold)
      (phase == PH_SLEEP) |=> (dac_reg == $past(dac_reg) || dac_reg == $past(dac_reg) - 1'b1));

   // R6
   go_single_chk: assert property (@(posedge clk) disable iff (!rst_n || rst_hold)
      play_go |=> !play_go);

   // R4
   go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n || rst_hold)
      play_go |-> (!busy_n && dac_en));

   // R5
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n || rst_hold)
      (phase == PH_PLAY && dec_done) |=> (busy_n && dac_code == MID));
endmodule

bind msg_playback_ctl msgctl_chk #(.CODE_W(CODE_W), .DAC_W(DAC_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rst_hold (rst_hold),
   .phase    (phase),
   .dac_reg  (dac_reg),
   .busy_n   (busy_n),
   .busy_oe  (busy_oe),
   .dac_en   (dac_en),
   .dac_code (dac_code),
   .play_go  (play_go),
   .dec_done (dec_done),
   .msg_sel  (msg_sel)
);

// File: tb/msg_playback_ctl_test.sv
`timescale 1ns/1ps
module msg_playback_ctl_test;
   localparam int RMIN = 12;
   localparam int RDIV = 2;
   localparam int IDLE = 40;
   localparam int MIDV = 256;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       st_n = 1'b1;
   logic [7:0] msg_code = 8'h00;
   logic       dec_done = 1'b0;
   logic [8:0] dec_sample = 9'h100;
   logic       busy_n, busy_oe, play_go, dac_en;
   logic [7:0] msg_sel;
   logic [8:0] dac_code;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   msg_playback_ctl #(.RST_MIN(RMIN), .RAMP_DIV(RDIV), .IDLE_CYC(IDLE)) uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .st_n(st_n), .msg_code(msg_code),
      .dec_done(dec_done), .dec_sample(dec_sample), .busy_n(busy_n), .busy_oe(busy_oe),
      .msg_sel(msg_sel), .play_go(play_go), .dac_code(dac_code), .dac_en(dac_en)
   );

   // behavioural reference: 0 standby, 1 rising, 2 playing, 3 waiting, 4 falling
   int m_st = 0, m_dac = 0, m_div = 0, m_idle = 0, m_code = 0, m_go = 0;
   int m_rc = 0, m_stq = 1;
   bit m_live = 0;

   always @(posedge clk) begin
      bit hold, rise, busy, acc, tick;
      hold = (m_rc == RMIN);
      rise = st_n && !m_stq && !cs_n;
      if (!rst_n) begin if (m_rc < RMIN) m_rc++; end else m_rc = 0;
      if (hold) begin
         m_live = 1; m_st = 0; m_dac = 0; m_div = 0; m_idle = 0;
         m_code = 0; m_go = 0; m_stq = 1;
      end else begin
         busy = (m_st == 1 || m_st == 2);
         acc = rise && !busy;
         m_stq = st_n;
         m_go = 0;
         tick = 0;
         if ((m_st == 1 || m_st == 4) && !acc) begin
            if (m_div == RDIV - 1) begin tick = 1; m_div = 0; end else m_div++;
         end else m_div = 0;
         if (acc) m_code = msg_code;
         case (m_st)
            0: if (acc) m_st = 1;
            1: if (tick) begin m_dac++; if (m_dac == MIDV) begin m_st = 2; m_go = 1; end end
            2: if (dec_done) begin m_st = 3; m_idle = 0; end
            3: if (acc) begin m_st = 2; m_go = 1; end
               else if (m_idle == IDLE - 1) m_st = 4;
               else m_idle++;
            4: if (acc) begin
                  if (m_dac == MIDV) begin m_st = 2; m_go = 1; end else m_st = 1;
               end else if (tick) begin m_dac--; if (m_dac == 0) m_st = 0; end
            default: m_st = 0;
         endcase
         if (m_st != 3) m_idle = 0;
      end
   end

   task automatic cmp(string sig, int act, int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, sig, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (m_live && !finished) begin
         cmp("busy_n", busy_n, !(m_st == 1 || m_st == 2));
         cmp("busy_oe", busy_oe, m_st != 0);
         cmp("dac_en", dac_en, m_st != 0);
         cmp("dac_code", dac_code, (m_st == 2) ? int'(dec_sample) : m_dac);
         cmp("play_go", play_go, m_go);
         cmp("msg_sel", msg_sel, m_code);
      end
   end

   task automatic chk(string req, string sig, int act, int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, sig, act, exp, $time);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic strobe(logic [7:0] code, logic cs);
      cs_n = cs; msg_code = code; st_n = 1'b0;
      cyc(2);
      st_n = 1'b1;
      cyc(1);
      cs_n = 1'b1;
   endtask

   task automatic wait_go(string req);
      bit seen = 0;
      for (int i = 0; i < 3000 && !seen; i++) begin
         if (play_go) seen = 1; else cyc(1);
      end
      chk(req, "play_go seen", seen, 1);
   endtask

   task automatic finish_msg();
      dec_done = 1'b1; cyc(1); dec_done = 1'b0;
      chk("R5", "busy_n after done", busy_n, 1);
      chk("R5", "dac_code after done", dac_code, MIDV);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      cyc(14);
      rst_n = 1'b1;
      cyc(1);
      // R1 and R9: reset state
      chk("R9", "busy_oe", busy_oe, 0);
      chk("R9", "dac_en", dac_en, 0);
      chk("R9", "dac_code", dac_code, 0);
      chk("R1", "busy_n", busy_n, 1);
      chk("R1", "msg_sel", msg_sel, 0);

      cur_req = "R2";
      strobe(8'h11, 1'b1);
      cyc(3);
      chk("R2", "dac_en no cs", dac_en, 0);
      chk("R2", "msg_sel no cs", msg_sel, 0);

      strobe(8'hA5, 1'b0);
      chk("R2", "msg_sel", msg_sel, 8'hA5);
      chk("R3", "busy_n", busy_n, 0);
      cur_req = "R4";
      cyc(20);
      chk("R4", "dac_en", dac_en, 1);
      cur_req = "R3";
      strobe(8'h3C, 1'b0);
      chk("R3", "msg_sel busy", msg_sel, 8'hA5);
      cur_req = "R4";
      wait_go("R4");

      cur_req = "R5";
      dec_sample = 9'h1FF; cyc(1); chk("R5", "dac_code", dac_code, 9'h1FF);
      dec_sample = 9'h000; cyc(1); chk("R5", "dac_code", dac_code, 9'h000);
      dec_sample = 9'h0AB; cyc(1); chk("R5", "dac_code", dac_code, 9'h0AB);
      dec_sample = 9'h100;
      finish_msg();

      cur_req = "R6";
      cyc(5);
      strobe(8'h5A, 1'b0);
      chk("R6", "msg_sel", msg_sel, 8'h5A);
      chk("R6", "busy_n", busy_n, 0);
      chk("R6", "dac_code", dac_code, MIDV);
      finish_msg();

      cur_req = "R7";
      cyc(IDLE + MIDV * RDIV + 6);
      chk("R7", "busy_oe", busy_oe, 0);
      chk("R9", "dac_en", dac_en, 0);
      chk("R9", "dac_code", dac_code, 0);

      cur_req = "R4";
      strobe(8'hC3, 1'b0);
      wait_go("R4");
      for (int k = 0; k < 2; k++) begin
         finish_msg();
         cur_req = "R8";
         cyc(IDLE + 100 + k);
         chk("R8", "ramping down", dac_en, 1);
         strobe(8'h70 + 8'(k), 1'b0);
         chk("R8", "busy_n", busy_n, 0);
         chk("R8", "msg_sel", msg_sel, 8'h70 + k);
         wait_go("R8");
      end

      cur_req = "R1";
      rst_n = 1'b0; cyc(5); rst_n = 1'b1; cyc(2);
      chk("R1", "short pulse busy_n", busy_n, 0);
      chk("R1", "short pulse msg_sel", msg_sel, 8'h71);
      finish_msg();
      rst_n = 1'b0; cyc(RMIN + 1); rst_n = 1'b1; cyc(1);
      chk("R1", "msg_sel", msg_sel, 0);
      chk("R1", "busy_oe", busy_oe, 0);
      cyc(4);
      summary();
   end
endmodule